// File: doc/BRIEF.md
# Self-Timed Write Cycle Sequencer with Write-Protect Abort

This block times the internal programming cycle of a small serial nonvolatile memory. The bus engine pulses `d0_capt_i` on the clock that follows the SCL rising edge sampling bit 0 of the first data byte of a write or protect command. That pulse marks data as pending and opens the write-protect cancel window. A later `stop_i` pulse turns the pending data into a programming cycle. The block pulses `commit_o` so the array latches the staged bytes, then holds `busy_o` high for `WR_CLKS` system clocks. While `busy_o` is high the bus engine refuses to acknowledge any slave address, which lets a host poll for completion.

The window stays open from the data capture through the last clock of the write time. If the protect input stays high for `WP_MIN` consecutive clocks inside it, the cycle is cancelled at once. The block pulses `aborted_o` and goes back to idle. A cancel during programming also pulses `poison_o`, which tells the array to mark the target bytes as undefined; a simulation model may fill them with X or a poison pattern. A normal end pulses `done_o`. The serial protocol and the protection policy live outside this block. All inputs are single-clock control pulses or levels already synchronised to `clk`, so there is no valid/ready data path at its edge.

Top module: `wrc_write_sequencer`

## Requirements
- R1: After reset, `busy_o`, `commit_o`, `done_o`, `aborted_o` and `poison_o` are all low.
- R2: A `stop_i` pulse with no pending data (no `d0_capt_i` since the last cycle ended) starts nothing: `busy_o` and `commit_o` stay low.
- R3: A `stop_i` pulse sampled while data is pending raises `busy_o` and a one-clock `commit_o` on the next clock, and `busy_o` then stays high for exactly `WR_CLKS` clocks.
- R4: When the write time runs out without a cancel, `busy_o` falls and `done_o` is high for that single clock.
- R5: `d0_capt_i` and `stop_i` pulses that arrive while `busy_o` is high are ignored: the busy length is unchanged and no further `commit_o` occurs.
- R6: The protect input is ignored while idle, before any data capture: no `aborted_o` occurs, and a following write completes normally.
- R7: With data pending but before `stop_i`, `wp_i` high for `WP_MIN` consecutive clocks gives a one-clock `aborted_o` without `poison_o`, and drops the pending data, so a later `stop_i` starts no cycle.
- R8: While `busy_o` is high, `wp_i` high for `WP_MIN` consecutive clocks ends the cycle. `busy_o` falls, and `aborted_o` and `poison_o` are both high for that one clock, `WP_MIN` clocks after `wp_i` was first sampled high. No `done_o` follows.
- R9: A `wp_i` pulse shorter than `WP_MIN` clocks inside the window has no effect.
- R10: `done_o` and `aborted_o` are never high together; a cancel whose qualifying clock coincides with the last write-time clock wins, giving `aborted_o` and no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d0_capt_i | input | 1 | One-clock pulse: bit 0 of the first data byte was captured |
| stop_i | input | 1 | One-clock pulse: STOP condition seen on the bus |
| wp_i | input | 1 | Write-protect pin level, already synchronised |
| busy_o | output | 1 | Programming cycle in progress; bus engine must not acknowledge |
| commit_o | output | 1 | One-clock pulse: array latches the staged bytes |
| done_o | output | 1 | One-clock pulse: programming cycle finished normally |
| aborted_o | output | 1 | One-clock pulse: cycle or pending data cancelled by write protect |
| poison_o | output | 1 | One-clock pulse with `aborted_o` when bytes being programmed are now undefined |

## Verification
The embedded properties assume that `d0_capt_i` and `stop_i` are one clock wide and that `wp_i` is synchronous to `clk`. They also assume the bus engine never raises a fresh capture while a cancel is still qualifying. The bench changes every input only on the falling clock edge and lowers each pulse on the next falling edge. It keeps `wp_i` low whenever a new write begins, so the random mix of glitch lengths and cancel points never breaks those assumptions. It also aims some cancels so that their qualifying clock lands on or just after the final write-time clock.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_PROG  = 2'd2
  } wr_state_e;
endpackage

// File: rtl/wrc_wp_filter.sv
module wrc_wp_filter #(
  parameter int WP_MIN = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_i,
  input  logic wp_i,
  output logic hit_o
);
  localparam int CW = (WP_MIN > 1) ? $clog2(WP_MIN) : 1;

  generate
    if (WP_MIN <= 1) begin : g_direct
      assign hit_o = win_i && wp_i;
    end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(WP_MIN - 1);
      logic [CW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (!win_i || !wp_i)  run_q <= '0;
        else if (run_q != LAST)    run_q <= run_q + 1'b1;
      end

      assign hit_o = win_i && wp_i && (run_q == LAST);

      // a qualifying cancel needs protect already high inside the window last clock
      p_hit_needs_history_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(wp_i) && $past(win_i)));
    end
  endgenerate
endmodule

// File: rtl/wrc_timer.sv
module wrc_timer #(
  parameter int WR_CLKS = 625000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (WR_CLKS > 1) ? $clog2(WR_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WR_CLKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (start_i)                  cnt_q <= '0;
    else if (run_i && cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // the run never starts and expires on the same clock
  p_no_instant_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (WR_CLKS == 1) || !expire_o);
endmodule

// File: rtl/wrc_write_sequencer.sv
module wrc_write_sequencer
  import wrc_pkg::*;
#(
  parameter int WR_CLKS = 625000,
  parameter int WP_MIN  = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d0_capt_i,
  input  logic stop_i,
  input  logic wp_i,
  output logic busy_o,
  output logic commit_o,
  output logic done_o,
  output logic aborted_o,
  output logic poison_o
);
  wr_state_e state_q;
  logic      win, wp_hit, expire, start;

  assign win   = (state_q != WS_IDLE);
  assign start = (state_q == WS_ARMED) && stop_i && !wp_hit;

  wrc_wp_filter #(.WP_MIN(WP_MIN)) u_filter (
    .clk(clk), .rst_n(rst_n), .win_i(win), .wp_i(wp_i), .hit_o(wp_hit)
  );

  wrc_timer #(.WR_CLKS(WR_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .run_i(state_q == WS_PROG), .expire_o(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      commit_o  <= 1'b0;
      done_o    <= 1'b0;
      aborted_o <= 1'b0;
      poison_o  <= 1'b0;
    end else begin
      commit_o  <= 1'b0;
      done_o    <= 1'b0;
      aborted_o <= 1'b0;
      poison_o  <= 1'b0;
      unique case (state_q)
        WS_IDLE: begin
          if (d0_capt_i) state_q <= WS_ARMED;
        end
        WS_ARMED: begin
          if (wp_hit) begin
            state_q   <= WS_IDLE;
            aborted_o <= 1'b1;
          end else if (stop_i) begin
            state_q  <= WS_PROG;
            commit_o <= 1'b1;
          end
        end
        WS_PROG: begin
          if (wp_hit) begin
            state_q   <= WS_IDLE;
            aborted_o <= 1'b1;
            poison_o  <= 1'b1;
          end else if (expire) begin
            state_q <= WS_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == WS_PROG);

  p_idle_stop_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_IDLE) |=> !busy_o && !commit_o);

  p_commit_starts_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (commit_o && $past(stop_i)));

  p_done_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_ends_cleanly_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o || aborted_o));

  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !wp_hit && !expire) |=> (busy_o && !commit_o));

  p_poison_with_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    poison_o |-> (aborted_o && $past(busy_o)));

  p_done_abort_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && aborted_o));
endmodule

// File: tb/wrc_write_sequencer_test.sv
module wrc_write_sequencer_test;
  localparam int WR  = 40;
  localparam int WPM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d0 = 1'b0, stop = 1'b0, wp = 1'b0;
  logic busy, commit, done, aborted, poison;
  int   n_chk = 0, n_bad = 0;
  bit   fin = 1'b0;

  always #4 clk = ~clk;

  wrc_write_sequencer #(.WR_CLKS(WR), .WP_MIN(WPM)) uut (
    .clk(clk), .rst_n(rst_n), .d0_capt_i(d0), .stop_i(stop), .wp_i(wp),
    .busy_o(busy), .commit_o(commit), .done_o(done),
    .aborted_o(aborted), .poison_o(poison)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // expected abort observation index for a protect pulse raised at sample wp_at
  function automatic int abort_obs(input int wp_at, input int wp_len);
    if (wp_at >= 1 && wp_len >= WPM && wp_at + WPM - 1 <= WR) return wp_at + WPM;
    return 0;
  endfunction

  task automatic do_write(input int arm_wait, input int arm_glitch,
                          input int wp_at, input int wp_len, input string req);
    int s_a, s_end, stray;
    @(negedge clk) d0 = 1'b1;
    @(negedge clk) d0 = 1'b0;
    chk("R2", "busy before stop", busy, 0);
    for (int k = 0; k < arm_wait; k++) begin
      wp = (k < arm_glitch);
      @(negedge clk);
      chk("R9", "aborted in armed glitch", aborted, 0);
    end
    wp = 1'b0;
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    s_a   = abort_obs(wp_at, wp_len);
    s_end = (s_a != 0) ? s_a : WR + 1;
    stray = (s_a == 0 || wp_at > 5) ? 3 : 0;
    for (int s = 1; s <= WR + 2; s++) begin
      if (s > 1) @(negedge clk);
      chk("R3", "commit", commit, (s == 1) ? 1 : 0);
      chk((s_a != 0) ? "R8" : "R3", "busy", busy, (s < s_end) ? 1 : 0);
      chk("R4", "done", done, (s_a == 0 && s == WR + 1) ? 1 : 0);
      chk(req, "aborted", aborted, (s == s_a) ? 1 : 0);
      chk("R8", "poison", poison, (s == s_a) ? 1 : 0);
      wp   = (wp_len > 0 && s >= wp_at && s < wp_at + wp_len);
      d0   = (s == stray);   // R5 stray command during busy
      stop = (s == stray);
    end
    wp = 1'b0; d0 = 1'b0; stop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "commit", commit, 0);
    chk("R1", "done", done, 0);
    chk("R1", "aborted", aborted, 0);
    chk("R1", "poison", poison, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: stop without pending data
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R2", "busy", busy, 0);
      chk("R2", "commit", commit, 0);
      @(negedge clk);
    end

    // R3/R4/R5: plain write
    do_write(0, 0, 0, 0, "R3");

    // R6: protect high while idle, then a normal write
    wp = 1'b1;
    for (int k = 0; k < 3 * WPM; k++) begin
      @(negedge clk);
      chk("R6", "aborted while idle", aborted, 0);
    end
    wp = 1'b0;
    @(negedge clk);
    do_write(1, 0, 0, 0, "R6");

    // R7: cancel while armed, then stop starts nothing
    @(negedge clk) d0 = 1'b1;
    @(negedge clk) begin d0 = 1'b0; wp = 1'b1; end
    repeat (WPM) @(negedge clk);
    chk("R7", "aborted", aborted, 1);
    chk("R7", "poison", poison, 0);
    chk("R7", "busy", busy, 0);
    wp = 1'b0;
    @(negedge clk);
    chk("R7", "aborted one clock", aborted, 0);
    stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk("R7", "busy after dropped data", busy, 0);
    chk("R7", "commit after dropped data", commit, 0);
    @(negedge clk);

    // R9: short glitch while armed and while busy
    do_write(WPM + 2, WPM - 1, 10, WPM - 1, "R9");
    // R8: cancel during busy
    do_write(0, 0, 12, WPM, "R8");
    // R10: qualifying clock equals last write-time clock
    do_write(0, 0, WR - WPM + 1, WPM + 2, "R10");
    // one clock later: window closed, normal done
    do_write(0, 0, WR - WPM + 2, WPM + 2, "R10");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int mode, aw, at, ln;
      mode = $urandom_range(0, 2);
      aw   = $urandom_range(0, 5);
      at   = $urandom_range(1, WR);
      ln   = (mode == 1) ? $urandom_range(1, WPM - 1) :
             (mode == 2) ? $urandom_range(WPM, WPM + 3) : 0;
      do_write(aw, (aw > 0) ? $urandom_range(0, WPM - 1) : 0,
               (mode == 0) ? 0 : at, ln, (mode == 2) ? "R8" : "R9");
    end

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule